// File: doc/BRIEF.md
# Transmit Sample Nibble Formatter

This block prepares signed transmit samples for a converter fed over four parallel data lines. Each 16-bit two's-complement sample from the signal processor is saturated to a 15-bit signed range. Its three lowest bits are then cleared, which leaves twelve significant bits: a duplicated sign and data bits d10 down to d0. The resulting word goes out as four successive 4-bit nibbles, N0 first and N3 last. A phase output flags the N0 period, so the receiving side can frame each word.

The producer offers samples with a valid/ready handshake. A sample is taken only in the last clock of N3, so that it starts going out at N0 on the next clock. If no sample is offered at that point, an all-zero word is sent instead and the line never stalls. A rate-select input picks normal rate or a half rate for compatibility with slower equipment. At half rate every nibble is held for two clocks. The rate is sampled only at word boundaries.

Top module: `tx_nibble_fmt`

## Requirements
- R1: A sample above +16383 is sent as +16383 with its low three bits cleared, giving the word 0x3FF8.
- R2: A sample below -16384 is sent as -16384, giving the word 0xC000. Samples inside the range keep their value apart from the cleared low bits.
- R3: Bits 2..0 of every transmitted word are zero, so lines 0, 1 and 2 are low during N0.
- R4: Bits 15 and 14 of every transmitted word are equal, so lines 2 and 3 carry the same sign value during N3.
- R5: Nibbles leave in the order N0, N1, N2, N3. During nibble Nk, line j (bit j of `nib_out`) carries bit 4k+j of the formatted word.
- R6: `nib_phase0` is high during exactly the clocks that carry N0.
- R7: `in_ready` is high only in the final clock of N3. A sample with `in_valid` high at that edge is accepted, and its N0 appears on the next clock.
- R8: If `in_valid` is low when `in_ready` is high, the next word sent is all zeros, whatever `in_data` holds.
- R9: With `mode_half` = 1 latched for a word, each of its nibbles is held for two clocks (8 clocks per word). With 0, each nibble lasts one clock (4 clocks per word).
- R10: `mode_half` is sampled only at the accepting edge (the final clock of N3). Changes at any other time do not affect the word in flight.
- R11: After reset, `nib_out` is 0 and `nib_phase0` is 0. The block then sits in the final clock of an all-zero word at normal rate, with `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_data | input | 16 | Signed two's-complement sample |
| in_ready | output | 1 | High in the final clock of N3; the sample is taken at this edge |
| mode_half | input | 1 | 1 = half rate (each nibble held two clocks) |
| nib_out | output | 4 | Data lines; bit j is line j |
| nib_phase0 | output | 1 | High while N0 is on the lines |

## Verification
The embedded properties assume only that `in_valid`, `in_data` and `mode_half` are stable at each rising edge and free of X once reset is released. The bench therefore changes them on falling edges only, and drives them from time zero. The properties make no assumption about when the producer offers data. Because of this, the stimulus mixes offered and withheld samples, extreme and random values, and words where `mode_half` is scrambled during the word in flight, while every accept still happens in the final clock of N3.

// File: rtl/tx_nib_pkg.sv
package tx_nib_pkg;
   typedef enum logic {
      RATE_FULL = 1'b0,
      RATE_HALF = 1'b1
   } rate_e;
endpackage

// File: rtl/tx_nib_sat.sv
module tx_nib_sat #(
   parameter int IN_W     = 16,
   parameter int SAT_W    = 15,
   parameter int ZERO_LSB = 3
) (
   input  logic [IN_W-1:0] din,
   output logic [IN_W-1:0] dout
);
   localparam int HEAD = IN_W - SAT_W + 1;

   logic [HEAD-1:0] head;
   logic            ovf;
   logic [IN_W-1:0] sat;

   assign head = din[IN_W-1:SAT_W-1];
   assign ovf  = (|head) && !(&head);

   always_comb begin
      if (!ovf)
         sat = din;
      else if (din[IN_W-1])
         sat = {{HEAD{1'b1}}, {(SAT_W-1){1'b0}}};
      else
         sat = {{HEAD{1'b0}}, {(SAT_W-1){1'b1}}};
   end

   generate
      if (ZERO_LSB > 0) begin : g_trim
         assign dout = {sat[IN_W-1:ZERO_LSB], {ZERO_LSB{1'b0}}};
      end else begin : g_keep
         assign dout = sat;
      end
   endgenerate
endmodule

// File: rtl/tx_nib_seq.sv
module tx_nib_seq
   import tx_nib_pkg::*;
#(
   parameter int NIBBLES = 4,
   parameter int STRETCH = 2,
   localparam int SLOT_W = $clog2(NIBBLES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_in,
   output logic [SLOT_W-1:0] slot,
   output logic              word_end
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NIBBLES - 1);

   rate_e             rate_q;
   logic [SLOT_W-1:0] slot_q;
   logic              last_sub;

   generate
      if (STRETCH > 1) begin : g_stretch
         localparam int SUB_W = $clog2(STRETCH);
         logic [SUB_W-1:0] sub_q;

         assign last_sub = (rate_q == RATE_FULL) || (sub_q == SUB_W'(STRETCH - 1));

         always_ff @(posedge clk) begin
            if (rst || last_sub)
               sub_q <= '0;
            else
               sub_q <= sub_q + 1'b1;
         end

         // R9
         hold_slot_chk: assert property (@(posedge clk) disable iff (rst)
            (rate_q == RATE_HALF && sub_q == '0) |=> (slot_q == $past(slot_q)));
      end else begin : g_plain
         assign last_sub = 1'b1;
      end
   endgenerate

   assign word_end = last_sub && (slot_q == LAST);
   assign slot     = slot_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q <= LAST;
         rate_q <= RATE_FULL;
      end else if (last_sub) begin
         if (word_end) begin
            slot_q <= '0;
            rate_q <= mode_in ? RATE_HALF : RATE_FULL;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   // R10
   rate_locked_chk: assert property (@(posedge clk) disable iff (rst)
      !word_end |=> (rate_q == $past(rate_q)));
endmodule

// File: rtl/tx_nib_ser.sv
module tx_nib_ser #(
   parameter int LANES   = 4,
   parameter int NIBBLES = 4,
   localparam int W      = LANES * NIBBLES,
   localparam int SLOT_W = $clog2(NIBBLES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [W-1:0]      word_in,
   input  logic [SLOT_W-1:0] slot,
   output logic [LANES-1:0]  nib_out,
   output logic              phase0
);
   logic [W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (rst)
         word_q <= '0;
      else if (load)
         word_q <= word_in;
   end

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         always_comb begin
            nib_out[j] = 1'b0;
            for (int k = 0; k < NIBBLES; k++)
               if (slot == SLOT_W'(k))
                  nib_out[j] = word_q[k*LANES + j];
         end
      end
   endgenerate

   assign phase0 = (slot == '0);
endmodule

// File: rtl/tx_nibble_fmt.sv
module tx_nibble_fmt #(
   parameter int IN_W     = 16,
   parameter int SAT_W    = 15,
   parameter int ZERO_LSB = 3,
   parameter int LANES    = 4,
   parameter int STRETCH  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             in_ready,
   input  logic             mode_half,
   output logic [LANES-1:0] nib_out,
   output logic             nib_phase0
);
   localparam int NIBBLES  = IN_W / LANES;
   localparam int SLOT_W   = $clog2(NIBBLES);
   localparam int N0_ZERO  = (ZERO_LSB < LANES) ? ZERO_LSB : LANES;
   localparam logic [LANES-1:0] N0_MASK = LANES'((1 << N0_ZERO) - 1);

   generate
      if (IN_W % LANES != 0) begin : g_bad_lanes
         $error("IN_W must be a multiple of LANES");
      end
      if (NIBBLES < 2) begin : g_bad_nib
         $error("at least two nibbles per word are required");
      end
      if (SAT_W >= IN_W || SAT_W < 2) begin : g_bad_sat
         $error("SAT_W must lie between 2 and IN_W-1");
      end
      if (ZERO_LSB >= SAT_W - 1) begin : g_bad_trim
         $error("ZERO_LSB leaves no data bits");
      end
      if (STRETCH < 1) begin : g_bad_stretch
         $error("STRETCH must be at least 1");
      end
   endgenerate

   logic [IN_W-1:0]   fmt_word;
   logic [IN_W-1:0]   load_word;
   logic [SLOT_W-1:0] slot;
   logic              word_end;

   tx_nib_sat #(.IN_W(IN_W), .SAT_W(SAT_W), .ZERO_LSB(ZERO_LSB)) u_sat (
      .din  (in_data),
      .dout (fmt_word)
   );

   tx_nib_seq #(.NIBBLES(NIBBLES), .STRETCH(STRETCH)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .mode_in  (mode_half),
      .slot     (slot),
      .word_end (word_end)
   );

   assign load_word = in_valid ? fmt_word : '0;
   assign in_ready  = word_end;

   tx_nib_ser #(.LANES(LANES), .NIBBLES(NIBBLES)) u_ser (
      .clk     (clk),
      .rst     (rst),
      .load    (word_end),
      .word_in (load_word),
      .slot    (slot),
      .nib_out (nib_out),
      .phase0  (nib_phase0)
   );

   // R1
   sat_range_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ((&fmt_word[IN_W-1:SAT_W-1]) || !(|fmt_word[IN_W-1:SAT_W-1])));

   // R7
   accept_n0_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> nib_phase0);

   // R3
   low_lines_chk: assert property (@(posedge clk) disable iff (rst)
      nib_phase0 |-> ((nib_out & N0_MASK) == '0));

   // R4
   sign_pair_chk: assert property (@(posedge clk) disable iff (rst)
      (slot == SLOT_W'(NIBBLES - 1)) |-> (nib_out[LANES-1] == nib_out[LANES-2]));

   // R8
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_ready && !in_valid) |=> (nib_out == '0));
endmodule

// File: tb/tx_nibble_fmt_test.sv
module tx_nibble_fmt_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = 16'h0;
   logic        mode_half = 1'b0;
   logic        in_ready;
   logic [3:0]  nib_out;
   logic        nib_phase0;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   tx_nibble_fmt uut (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_ready   (in_ready),
      .mode_half  (mode_half),
      .nib_out    (nib_out),
      .nib_phase0 (nib_phase0)
   );

   function automatic logic [15:0] fmt_exp(input logic [15:0] d);
      int v;
      v = int'($signed(d));
      if (v > 16383)  v = 16383;
      if (v < -16384) v = -16384;
      return 16'(v) & 16'hFFF8;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Called at a falling edge inside the final clock of N3; returns in the same position.
   task automatic send_word(input bit valid, input logic [15:0] data, input bit half,
                            input bit scramble, input string tag);
      logic [15:0] exp;
      int reps;
      bit last;
      chk(in_ready == 1'b1, "R7 ready at boundary", int'(in_ready), 1);
      in_valid  = valid;
      in_data   = data;
      mode_half = half;
      exp  = valid ? fmt_exp(data) : 16'h0;
      reps = half ? 2 : 1;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'($urandom);
      for (int k = 0; k < 4; k++) begin
         for (int r = 0; r < reps; r++) begin
            last = (k == 3) && (r == reps - 1);
            if (scramble) mode_half = 1'($urandom);
            chk(nib_out == exp[4*k +: 4], half ? "R9 half-rate nibble" : tag,
                int'(nib_out), int'(exp[4*k +: 4]));
            chk(nib_phase0 == (k == 0), "R6 phase marker", int'(nib_phase0), int'(k == 0));
            chk(in_ready == last, "R7 ready timing", int'(in_ready), int'(last));
            if (k == 0)
               chk(nib_out[2:0] == 3'b000, "R3 low lines in N0", int'(nib_out[2:0]), 0);
            if (k == 3)
               chk(nib_out[3] == nib_out[2], "R4 sign lines in N3", int'(nib_out[3]), int'(nib_out[2]));
            if (!last) @(negedge clk);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog: actual stalled expected progress");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R11 reset state
      chk(nib_out == 4'h0, "R11 reset nib_out", int'(nib_out), 0);
      chk(nib_phase0 == 1'b0, "R11 reset phase", int'(nib_phase0), 0);
      chk(in_ready == 1'b1, "R11 reset ready", int'(in_ready), 1);

      send_word(1'b1, 16'h7FFF, 1'b0, 1'b0, "R1 clamp max");
      send_word(1'b1, 16'h4000, 1'b0, 1'b0, "R1 clamp just above");
      send_word(1'b1, 16'h3FFF, 1'b0, 1'b0, "R2 in-range top");
      send_word(1'b1, 16'h8000, 1'b0, 1'b0, "R2 clamp min");
      send_word(1'b1, 16'hBFFF, 1'b0, 1'b0, "R2 clamp just below");
      send_word(1'b1, 16'hC000, 1'b0, 1'b0, "R2 in-range bottom");
      send_word(1'b1, 16'hFFFF, 1'b0, 1'b0, "R3 minus one");
      send_word(1'b1, 16'h1234, 1'b0, 1'b0, "R5 mapping");
      send_word(1'b1, 16'h2A5F, 1'b0, 1'b0, "R5 mapping");
      send_word(1'b0, 16'h3C3C, 1'b0, 1'b0, "R8 idle word");
      send_word(1'b1, 16'h7FFF, 1'b1, 1'b0, "R9 half max");
      send_word(1'b0, 16'h1FFF, 1'b1, 1'b0, "R8 idle half");
      send_word(1'b1, 16'h8001, 1'b1, 1'b0, "R9 half min");
      send_word(1'b1, 16'h0A5C, 1'b0, 1'b1, "R10 full rate, mode toggled");
      send_word(1'b1, 16'hF5A8, 1'b1, 1'b1, "R10 half rate, mode toggled");
      send_word(1'b1, 16'h1357, 1'b0, 1'b1, "R10 back to full");

      for (int i = 0; i < 400; i++) begin
         logic [15:0] d;
         bit          v;
         bit          h;
         d = 16'($urandom);
         if ($urandom % 6 == 0) d = {d[15], {15{~d[15]}}};
         v = ($urandom % 5) != 0;
         h = ($urandom % 4) == 0;
         send_word(v, d, h, 1'($urandom), "R5 random word");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule